// File: doc/BRIEF.md
# Dual Frame Buffer Burst Sequencer

This block turns one or two frame buffers in memory into a steady stream of read-burst requests that refill a display FIFO. Each buffer is given as a byte base address and an inclusive ceiling address, the last byte of the buffer, so the ceiling is base plus size minus one. The sequencer walks the active buffer from base to ceiling in bursts of a programmable number of 32-bit words. It shortens the final burst so that the burst ends exactly on the ceiling. When a buffer has been fully requested, the sequencer pulses that buffer's end-of-frame flag.

In single mode only buffer 0 is read, frame after frame. In dual mode the sequencer alternates between buffer 0 and buffer 1. A buffer's base and ceiling are captured when that buffer's frame begins. Software may therefore rewrite a buffer's addresses after its end-of-frame pulse, and the new values apply the next time that buffer is started.

On the memory side there is a single request with address and length, held until it is acknowledged. On the FIFO side the sequencer sees the FIFO fill level. It issues a burst only when the FIFO can hold the whole burst, and it reports a ready indication once the fill level reaches a programmable threshold.

Top module: `fb_burst_seq`

## Requirements
- R1: After reset `mem_req` is 0 and `frame_done` is 0.
- R2: A frame's first burst starts at the buffer's base address. Each later burst starts where the previous one ended, the address advancing by 4 bytes per word of `mem_len`.
- R3: `burst_log` selects the nominal burst length in words: values 0, 1, 2, 3 and 4 give 1, 2, 4, 8 and 16 words, and any value above 4 gives 16 words.
- R4: The final burst of a frame is shortened to the number of words left, so that its last byte is the ceiling address. No burst passes the ceiling.
- R5: One cycle after the handshake that accepts a frame's final burst, `frame_done` pulses for exactly one cycle. Bit 0 is set for buffer 0 and bit 1 for buffer 1, and the two bits are never set together.
- R6: With `dual_en`=1 at a frame's end, the next frame uses the other buffer. With `dual_en`=0 the next frame uses buffer 0, so `frame_done[1]` stays 0 in single-buffer operation.
- R7: Base and ceiling are captured when a buffer's frame begins. Changes to `bufN_base`/`bufN_ceil` during that frame do not affect it and take effect the next time the buffer starts.
- R8: A burst is requested only if `FIFO_DEPTH - fifo_level` (free words) is at least its length in the cycle the request is decided. A free count exactly equal to the length is enough.
- R9: While `mem_req` is 1 and `mem_ack` is 0, `mem_req`, `mem_addr` and `mem_len` hold their values into the next cycle.
- R10: `fifo_ready` is 1 exactly when `fifo_level` is greater than or equal to `fifo_thresh`.
- R11: When `run_en` is 0, a burst already requested completes and no new burst is requested. Raising `run_en` again starts a frame at buffer 0's base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Sequencer run enable |
| dual_en | input | 1 | 1: alternate buffers 0 and 1; 0: buffer 0 only |
| burst_log | input | LOG_W (3) | log2 of nominal burst length in words |
| fifo_thresh | input | THR_W (8) | Fill level at which the FIFO counts as ready |
| fifo_level | input | LVL_W (7) | Words currently held in the display FIFO |
| fifo_ready | output | 1 | FIFO fill level has reached the threshold |
| buf0_base | input | ADDR_W (32) | Buffer 0 first byte address |
| buf0_ceil | input | ADDR_W (32) | Buffer 0 last byte address (inclusive) |
| buf1_base | input | ADDR_W (32) | Buffer 1 first byte address |
| buf1_ceil | input | ADDR_W (32) | Buffer 1 last byte address (inclusive) |
| mem_req | output | 1 | Burst read request |
| mem_addr | output | ADDR_W (32) | Burst start byte address |
| mem_len | output | LEN_W (5) | Burst length in words |
| mem_ack | input | 1 | Memory accepts the pending burst |
| frame_done | output | 2 | One-cycle end-of-frame pulse per buffer |

## Verification
The assertions take for granted that every buffer is word aligned with a ceiling at or above its base, that the ceiling is the last byte of a whole word, and that `fifo_level` never exceeds `FIFO_DEPTH`. The stimulus draws every buffer region as an aligned base plus 1 to 40 whole words and draws fill levels only from 0 to the depth. `burst_log` and `dual_en` are changed only while the sequencer is stopped, and the bench confirms that state by seeing no request for a stretch of cycles first. Buffer addresses, by contrast, are rewritten at random at any time, in the middle of frames as well, to exercise the capture rule.

// File: rtl/fb_burst_seq_pkg.sv
package fb_burst_seq_pkg;

    localparam int MAX_LOG         = 4;
    localparam int MAX_BURST_WORDS = 1 << MAX_LOG;
    localparam int BYTES_PER_WORD  = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_REQ  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/fb_burst_seq_len.sv
module fb_burst_seq_len
    import fb_burst_seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LOG_W  = 3,
    parameter int LEN_W  = 5
) (
    input  logic [LOG_W-1:0]  burst_log,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [ADDR_W-1:0] ceil_addr,
    output logic [LEN_W-1:0]  len
);

    logic [LEN_W-1:0]  pow_tbl [MAX_LOG+1];
    logic [LOG_W-1:0]  nom_idx;
    logic [LEN_W-1:0]  nom_len;
    logic [ADDR_W-1:0] span;
    logic [ADDR_W-1:0] words_m1;

    for (genvar g = 0; g <= MAX_LOG; g++) begin : g_pow
        assign pow_tbl[g] = LEN_W'(1) << g;
    end

    assign nom_idx  = (burst_log > LOG_W'(MAX_LOG)) ? LOG_W'(MAX_LOG) : burst_log;
    assign span     = ceil_addr - cur_addr;
    assign words_m1 = span >> 2;

    always_comb begin
        nom_len = pow_tbl[MAX_LOG];
        for (int i = 0; i <= MAX_LOG; i++) begin
            if (i == int'(nom_idx)) begin
                nom_len = pow_tbl[i];
            end
        end
    end

    always_comb begin
        if (words_m1 < ADDR_W'(nom_len)) begin
            len = LEN_W'(words_m1) + LEN_W'(1);
        end else begin
            len = nom_len;
        end
    end

endmodule

// File: rtl/fb_burst_seq_gate.sv
module fb_burst_seq_gate #(
    parameter int FIFO_DEPTH = 64,
    parameter int LVL_W      = 7,
    parameter int THR_W      = 8,
    parameter int LEN_W      = 5
) (
    input  logic [LVL_W-1:0] fifo_level,
    input  logic [THR_W-1:0] fifo_thresh,
    input  logic [LEN_W-1:0] want_len,
    output logic             room_ok,
    output logic             ready
);

    logic [LVL_W-1:0] free_words;

    always_comb begin
        if (32'(fifo_level) > 32'(FIFO_DEPTH)) begin
            free_words = '0;
        end else begin
            free_words = LVL_W'(FIFO_DEPTH) - fifo_level;
        end
    end

    assign room_ok = 32'(free_words) >= 32'(want_len);
    assign ready   = 32'(fifo_level) >= 32'(fifo_thresh);

endmodule

// File: rtl/fb_burst_seq.sv
module fb_burst_seq
    import fb_burst_seq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int FIFO_DEPTH = 64,
    parameter int THR_W      = 8,
    parameter int LOG_W      = 3,
    localparam int LEN_W     = $clog2(MAX_BURST_WORDS + 1),
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              dual_en,
    input  logic [LOG_W-1:0]  burst_log,
    input  logic [THR_W-1:0]  fifo_thresh,
    input  logic [LVL_W-1:0]  fifo_level,
    output logic              fifo_ready,
    input  logic [ADDR_W-1:0] buf0_base,
    input  logic [ADDR_W-1:0] buf0_ceil,
    input  logic [ADDR_W-1:0] buf1_base,
    input  logic [ADDR_W-1:0] buf1_ceil,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LEN_W-1:0]  mem_len,
    input  logic              mem_ack,
    output logic [1:0]        frame_done
);

    localparam int NBUF = 2;

    typedef struct packed {
        seq_state_e        state;
        logic              cur_buf;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] ceil;
        logic [LEN_W-1:0]  len;
        logic [NBUF-1:0]   done;
    } seq_regs_t;

    seq_regs_t regs_d, regs_q;

    logic [ADDR_W-1:0] base_arr [NBUF];
    logic [ADDR_W-1:0] ceil_arr [NBUF];
    logic [LEN_W-1:0]  calc_len;
    logic              room_ok;
    logic [ADDR_W:0]   end_wide;
    logic              last_burst;
    logic              next_buf;
    logic              accept;
    logic [NBUF-1:0]   done_hit;
    logic [ADDR_W-1:0] act_ceil;

    assign base_arr[0] = buf0_base;
    assign base_arr[1] = buf1_base;
    assign ceil_arr[0] = buf0_ceil;
    assign ceil_arr[1] = buf1_ceil;

    fb_burst_seq_len #(
        .ADDR_W (ADDR_W),
        .LOG_W  (LOG_W),
        .LEN_W  (LEN_W)
    ) u_len (
        .burst_log (burst_log),
        .cur_addr  (regs_q.addr),
        .ceil_addr (regs_q.ceil),
        .len       (calc_len)
    );

    fb_burst_seq_gate #(
        .FIFO_DEPTH (FIFO_DEPTH),
        .LVL_W      (LVL_W),
        .THR_W      (THR_W),
        .LEN_W      (LEN_W)
    ) u_gate (
        .fifo_level  (fifo_level),
        .fifo_thresh (fifo_thresh),
        .want_len    (calc_len),
        .room_ok     (room_ok),
        .ready       (fifo_ready)
    );

    // End address of the pending burst, one bit wider to avoid wrap.
    assign end_wide   = {1'b0, regs_q.addr}
                      + (ADDR_W+1)'({regs_q.len, 2'b00});
    assign last_burst = end_wide > {1'b0, regs_q.ceil};
    assign next_buf   = dual_en ? ~regs_q.cur_buf : 1'b0;
    assign accept     = (regs_q.state == ST_REQ) && mem_ack;

    for (genvar g = 0; g < NBUF; g++) begin : g_done
        assign done_hit[g] = accept && last_burst && (regs_q.cur_buf == 1'(g));
    end

    always_comb begin
        regs_d      = regs_q;
        regs_d.done = done_hit;
        unique case (regs_q.state)
            ST_IDLE: begin
                if (run_en) begin
                    regs_d.cur_buf = 1'b0;
                    regs_d.addr    = base_arr[0];
                    regs_d.ceil    = ceil_arr[0];
                    regs_d.state   = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (!run_en) begin
                    regs_d.state = ST_IDLE;
                end else if (room_ok) begin
                    regs_d.len   = calc_len;
                    regs_d.state = ST_REQ;
                end
            end
            ST_REQ: begin
                if (mem_ack) begin
                    regs_d.addr  = end_wide[ADDR_W-1:0];
                    regs_d.state = run_en ? ST_WAIT : ST_IDLE;
                    if (last_burst) begin
                        regs_d.cur_buf = next_buf;
                        regs_d.addr    = base_arr[next_buf];
                        regs_d.ceil    = ceil_arr[next_buf];
                    end
                end
            end
            default: begin
                regs_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{state: ST_IDLE, cur_buf: 1'b0, addr: '0,
                        ceil: '0, len: '0, done: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign mem_req    = (regs_q.state == ST_REQ);
    assign mem_addr   = regs_q.addr;
    assign mem_len    = regs_q.len;
    assign frame_done = regs_q.done;
    assign act_ceil   = regs_q.ceil;

endmodule

// File: rtl/fb_burst_seq_chk.sv
module fb_burst_seq_chk
    import fb_burst_seq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int FIFO_DEPTH = 64,
    parameter int LEN_W      = 5,
    parameter int LVL_W      = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [LEN_W-1:0]  mem_len,
    input logic [LVL_W-1:0]  fifo_level,
    input logic [1:0]        frame_done,
    input logic [ADDR_W-1:0] act_ceil
);

    logic [31:0]     free_w;
    logic [ADDR_W:0] last_byte;

    assign free_w    = 32'(FIFO_DEPTH) - 32'(fifo_level);
    assign last_byte = {1'b0, mem_addr} + (ADDR_W+1)'({mem_len, 2'b00})
                     - (ADDR_W+1)'(1);

    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_len));

    p_room_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past(free_w) >= 32'(mem_len));

    p_ceiling_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> last_byte <= {1'b0, act_ceil});

    p_len_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_len != '0) && (32'(mem_len) <= MAX_BURST_WORDS));

    p_eof_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(frame_done));

    p_eof_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done != 2'b00) |-> $past(mem_req && mem_ack));

endmodule

bind fb_burst_seq fb_burst_seq_chk #(
    .ADDR_W     (ADDR_W),
    .FIFO_DEPTH (FIFO_DEPTH),
    .LEN_W      (LEN_W),
    .LVL_W      (LVL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_req    (mem_req),
    .mem_ack    (mem_ack),
    .mem_addr   (mem_addr),
    .mem_len    (mem_len),
    .fifo_level (fifo_level),
    .frame_done (frame_done),
    .act_ceil   (act_ceil)
);

// File: tb/test_fb_burst_seq.sv
`timescale 1ns/1ps
module test_fb_burst_seq;

    localparam int ADDR_W = 32;
    localparam int DEPTH  = 64;
    localparam int LEN_W  = 5;
    localparam int LVL_W  = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              run_en = 1'b0;
    logic              dual_en = 1'b0;
    logic [2:0]        burst_log = 3'd4;
    logic [7:0]        fifo_thresh = 8'd8;
    logic [LVL_W-1:0]  fifo_level = '0;
    logic              fifo_ready;
    logic [ADDR_W-1:0] buf0_base = '0;
    logic [ADDR_W-1:0] buf0_ceil = 32'h3;
    logic [ADDR_W-1:0] buf1_base = '0;
    logic [ADDR_W-1:0] buf1_ceil = 32'h3;
    logic              mem_req;
    logic [ADDR_W-1:0] mem_addr;
    logic [LEN_W-1:0]  mem_len;
    logic              mem_ack = 1'b0;
    logic [1:0]        frame_done;

    fb_burst_seq i_fb_burst_seq (
        .clk (clk), .rst_n (rst_n), .run_en (run_en), .dual_en (dual_en),
        .burst_log (burst_log), .fifo_thresh (fifo_thresh),
        .fifo_level (fifo_level), .fifo_ready (fifo_ready),
        .buf0_base (buf0_base), .buf0_ceil (buf0_ceil),
        .buf1_base (buf1_base), .buf1_ceil (buf1_ceil),
        .mem_req (mem_req), .mem_addr (mem_addr), .mem_len (mem_len),
        .mem_ack (mem_ack), .frame_done (frame_done)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // control from the main sequence, applied in the negedge process
    bit          want_en = 0;
    bit          reprog_on = 0;
    int          lvl_force = -1;
    bit          pend_valid [2];
    logic [31:0] pend_base [2];
    logic [31:0] pend_ceil [2];

    // reference model
    bit          mbuf;
    logic [31:0] maddr;
    logic [31:0] mceil;
    logic [1:0]  exp_eof = 2'b00;
    int          eof_cnt = 0;
    int          eof1_cnt = 0;
    int          rise_cnt = 0;
    bit          prev_req = 0;
    bit          prev_ack = 0;
    logic [31:0] prev_addr;
    logic [4:0]  prev_len;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int nominal(input logic [2:0] lg);
        return (lg > 3'd4) ? 16 : (1 << lg);
    endfunction

    function automatic int expect_len(input logic [31:0] a, input logic [31:0] c,
                                      input logic [2:0] lg);
        int rem;
        rem = int'((c - a) >> 2) + 1;
        return (rem < nominal(lg)) ? rem : nominal(lg);
    endfunction

    task automatic rand_region(output logic [31:0] b, output logic [31:0] c);
        int words;
        words = $urandom_range(1, 40);
        b = {12'h0, 18'($urandom_range(0, 18'h3FFFF)), 2'b00};
        c = b + 32'(words * 4) - 32'd1;
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            for (int i = 0; i < 2; i++) begin
                if (pend_valid[i]) begin
                    if (i == 0) begin buf0_base = pend_base[i]; buf0_ceil = pend_ceil[i]; end
                    else        begin buf1_base = pend_base[i]; buf1_ceil = pend_ceil[i]; end
                    pend_valid[i] = 0;
                end
            end
        end else begin
            // R5 R6: end-of-frame pulse one cycle after the final handshake
            chk(frame_done == exp_eof, "R5 R6 frame_done", frame_done, exp_eof);
            exp_eof = 2'b00;
            // R10: ready level compare
            chk(fifo_ready == (32'(fifo_level) >= 32'(fifo_thresh)), "R10 fifo_ready",
                fifo_ready, 32'(fifo_level) >= 32'(fifo_thresh));
            // R9: request held until accepted
            if (prev_req && !prev_ack) begin
                chk(mem_req && mem_addr == prev_addr && mem_len == prev_len,
                    "R9 held request", {mem_req, mem_addr}, {1'b1, prev_addr});
            end
            // R8: room at decision time (fifo_level unchanged since that edge)
            if (mem_req && !prev_req) begin
                rise_cnt++;
                chk(DEPTH - int'(fifo_level) >= int'(mem_len), "R8 room",
                    DEPTH - int'(fifo_level), mem_len);
            end
            // buffer rewrites: pending ones from the sequence, then random
            for (int i = 0; i < 2; i++) begin
                if (pend_valid[i]) begin
                    if (i == 0) begin buf0_base = pend_base[i]; buf0_ceil = pend_ceil[i]; end
                    else        begin buf1_base = pend_base[i]; buf1_ceil = pend_ceil[i]; end
                    pend_valid[i] = 0;
                end
            end
            if (reprog_on && $urandom_range(0, 99) < 5) begin
                logic [31:0] nb, nc;
                rand_region(nb, nc);
                if ($urandom_range(0, 1) == 0) begin buf0_base = nb; buf0_ceil = nc; end
                else                           begin buf1_base = nb; buf1_ceil = nc; end
            end
            // run enable; a rising edge starts the model at buffer 0 (R11)
            if (run_en != want_en) begin
                run_en = want_en;
                if (want_en) begin
                    mbuf  = 0;
                    maddr = buf0_base;
                    mceil = buf0_ceil;
                end
            end
            // memory responder and model
            prev_req  = mem_req;
            prev_addr = mem_addr;
            prev_len  = mem_len;
            if (mem_req && $urandom_range(0, 9) < 6) begin
                int el;
                el = expect_len(maddr, mceil, burst_log);
                chk(mem_addr == maddr, "R2 R7 R11 burst address", mem_addr, maddr);
                chk(int'(mem_len) == el, "R3 R4 burst length", mem_len, el);
                maddr = maddr + 32'(el * 4);
                if (maddr > mceil) begin
                    exp_eof[mbuf] = 1'b1;
                    eof_cnt++;
                    if (mbuf) eof1_cnt++;
                    mbuf = dual_en ? ~mbuf : 1'b0;
                    maddr = mbuf ? buf1_base : buf0_base;
                    mceil = mbuf ? buf1_ceil : buf0_ceil;
                end
                mem_ack  <= 1'b1;
                prev_ack = 1;
            end else begin
                mem_ack  <= 1'b0;
                prev_ack = 0;
            end
            if (lvl_force >= 0) fifo_level = LVL_W'(lvl_force);
            else                fifo_level = LVL_W'($urandom_range(0, DEPTH));
            if ($urandom_range(0, 49) == 0) fifo_thresh = 8'($urandom_range(0, 80));
        end
    end

    task automatic set_buf(input int i, input logic [31:0] b, input int words);
        pend_base[i]  = b;
        pend_ceil[i]  = b + 32'(words * 4) - 32'd1;
        pend_valid[i] = 1;
        repeat (2) @(posedge clk);
        #1;
    endtask

    task automatic stop_and_check();
        want_en = 0;
        repeat (30) @(posedge clk);
        #1;
        rise_cnt = 0;
        repeat (20) @(posedge clk);
        @(negedge clk);
        #1;
        // R11: stopped sequencer issues nothing
        chk(rise_cnt == 0 && !mem_req, "R11 no burst while stopped", rise_cnt, 0);
        @(posedge clk);
        #1;
    endtask

    task automatic wait_frames(input int n);
        int target;
        target = eof_cnt + n;
        while (eof_cnt < target) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (4) @(posedge clk);
        #1;
        set_buf(0, 32'h0000_1000, 17);
        set_buf(1, 32'h0000_8000, 16);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1: reset state
        chk(!mem_req && frame_done == 2'b00, "R1 reset outputs", {mem_req, frame_done}, 0);
        @(posedge clk);
        #1;

        // directed: single mode, 17 words at 16-word bursts -> 16 then 1 (R3 R4 R6)
        dual_en   = 0;
        burst_log = 3'd4;
        want_en   = 1;
        wait_frames(3);
        chk(eof1_cnt == 0, "R6 single mode never ends buffer 1", eof1_cnt, 0);

        // directed R8: full FIFO blocks bursts, exactly-fitting free space allows them
        lvl_force = DEPTH;
        repeat (30) @(posedge clk);
        #1;
        rise_cnt = 0;
        repeat (30) @(posedge clk);
        #1;
        chk(rise_cnt == 0, "R8 no burst when FIFO full", rise_cnt, 0);
        lvl_force = DEPTH - 16;
        rise_cnt = 0;
        repeat (30) @(posedge clk);
        #1;
        chk(rise_cnt > 0, "R8 burst when free equals length", rise_cnt, 1);
        lvl_force = -1;
        stop_and_check();

        // directed: dual mode, 1-word bursts, mid-frame rewrite of buffer 0 (R7)
        dual_en   = 1;
        burst_log = 3'd0;
        set_buf(0, 32'h0000_2000, 6);
        want_en = 1;
        repeat (6) @(posedge clk);
        #1;
        set_buf(0, 32'h0000_3000, 3);
        wait_frames(4);
        chk(eof1_cnt >= 2, "R6 dual mode alternates to buffer 1", eof1_cnt, 2);
        stop_and_check();

        // random configurations, buffers rewritten at any time
        reprog_on = 1;
        for (int cfg = 0; cfg < 8; cfg++) begin
            int e1;
            dual_en   = (cfg % 3) != 0;
            burst_log = 3'(cfg);
            e1        = eof1_cnt;
            want_en   = 1;
            wait_frames(8);
            if (dual_en) chk(eof1_cnt > e1, "R6 dual buffer 1 used", eof1_cnt, e1 + 1);
            else         chk(eof1_cnt == e1, "R6 single buffer 1 unused", eof1_cnt, e1);
            stop_and_check();
        end
        reprog_on = 0;
        repeat (5) @(posedge clk);
        finish_run();
    end

endmodule